// File: doc/BRIEF.md
# Eight-Channel Output-Compare Action Unit

This block is the output-compare stage of a 16-bit timer. A free-running counter advances by one on every clock. Each of eight channels holds a 16-bit compare value. When the counter reaches a channel's compare value, the channel raises a one-cycle match pulse. That pulse applies the channel's programmed two-bit action to its output latch. The action can set the latch, clear it, toggle it, or leave it alone. Each channel also produces an output-enable that states whether the compare logic currently owns the pin.

Two masks change how a pin is owned:

- **Broadcast mask.** When a channel's bit is set, the highest channel's match drives that channel's pin to a per-channel preset value. The channel's own action code is then ignored.
- **Disconnect mask.** When a channel's bit is set, the channel releases its pin and its latch is frozen.

Software reaches all of this through a byte-wide register port with simple read and write strobes.

Register map (byte addresses):

| Address | Contents |
|---|---|
| 0x00 | Counter high byte (read-only) |
| 0x01 | Counter low byte (read-only) |
| 0x02 | Broadcast mask |
| 0x03 | Broadcast preset data |
| 0x08 | Action codes for channels 7..4 |
| 0x09 | Action codes for channels 3..0 |
| 0x0A | Disconnect mask |
| 0x10 + 2n | Channel n compare value, high byte |
| 0x11 + 2n | Channel n compare value, low byte |

Read data appears on `bus_rdata` one clock after the read strobe. It is zero in cycles with no read strobe.

Top module: `cmp_out_unit`

## Requirements
- R1: After reset, every writable register reads 0, and every `pin_o` and `pin_oe_o` bit is 0.
- R2: Action codes sit in two bytes, with the highest channel in the most significant pair. Address 0x08 bits [7:6],[5:4],[3:2],[1:0] hold channels 7,6,5,4, and address 0x09 holds channels 3,2,1,0 in the same arrangement. In each pair the upper bit is the mode bit and the lower bit is the level bit. Both bytes read back exactly what was written.
- R3: Code 01 (mode 0, level 1) inverts the channel's pin once per compare match.
- R4: Code 10 drives the pin to 0 on a match, and code 11 drives it to 1 on a match.
- R5: Code 00 leaves the pin unchanged on a match. With its broadcast bit at 0, the channel's `pin_oe_o` is 0.
- R6: `pin_oe_o[n]` is 1 when channel n's disconnect bit is 0 and either its code is nonzero or its broadcast bit is 1. It follows a register write within two clocks.
- R7: While disconnect bit n is 1, `pin_oe_o[n]` is 0 and `pin_o[n]` holds its value through matches. When the bit is cleared again, toggling continues from the held value.
- R8: While broadcast bit n is 1, channel n ignores its own code and its own match. A match on channel 7 instead drives `pin_o[n]` to preset bit n.
- R9: Reads of unassigned addresses (0x04–0x07, 0x0B–0x0F) return 0. Writes to those addresses and to the counter change no register.
- R10: A match is a single-cycle pulse: a compare value that is left unchanged produces one action per counter pass.
- R11: The counter starts at 0 after reset and increments by 1 each clock, wrapping at 2^16. A read of address 0x01 returns its low byte as it stood at the clock edge that captured the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_o | output | 8 | Per-channel output pin values |
| pin_oe_o | output | 8 | Per-channel output enables |

## Verification
The bound checker watches several properties on every clock:

- the counter steps by one each cycle;
- a match stays high for only one cycle while its compare value is steady;
- a toggle-coded match inverts the pin;
- a disconnected channel drops its enable and freezes its pin;
- a broadcast-masked pin moves only on a channel-7 match;
- a code-00 channel keeps its enable low.

The bench scenarios are the only place where several other behaviours show up: the byte and bit placement of the action codes, the resulting pin level after each code sequence, the resumption of toggling after a disconnect, the broadcast preset value reaching the pin, and the behaviour of unassigned addresses.

// File: rtl/cmp_out_pkg.sv
package cmp_out_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } act_e;

  // byte addresses of the register port
  localparam int unsigned CNT_BASE  = 32'h00;
  localparam int unsigned OVM_ADDR  = 32'h02;
  localparam int unsigned OVD_ADDR  = 32'h03;
  localparam int unsigned CTL_BASE  = 32'h08;
  localparam int unsigned DISC_ADDR = 32'h0A;
  localparam int unsigned CMP_BASE  = 32'h10;

endpackage

// File: rtl/cmp_free_counter.sv
module cmp_free_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o
);

  always_ff @(posedge clk) begin
    if (rst) cnt_o <= '0;
    else     cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/cmp_reg_bank.sv
module cmp_reg_bank
  import cmp_out_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic                 rd,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [CNT_W-1:0]     cnt,
  output logic [DATA_W-1:0]    rdata,
  output logic [2*NCH-1:0]     ctl_vec,
  output logic [NCH*CNT_W-1:0] cmp_flat,
  output logic [NCH-1:0]       ov_mask,
  output logic [NCH-1:0]       ov_data,
  output logic [NCH-1:0]       disc_mask
);

  localparam int BPC       = CNT_W / DATA_W;
  localparam int CMP_BYTES = NCH * BPC;
  localparam int CTL_W     = 2 * NCH;
  localparam int CTL_BYTES = CTL_W / DATA_W;
  localparam int IDX_W     = $clog2(CMP_BYTES);

  logic [31:0]       a32;
  logic              hit_cmp;
  logic [IDX_W-1:0]  cmp_idx;
  logic [DATA_W-1:0] rd_mux;

  logic [CTL_W-1:0]  ctl_q;
  logic [NCH-1:0]    ovm_q, ovd_q, disc_q;
  logic [DATA_W-1:0] cmp_mem [CMP_BYTES];

  assign a32     = 32'(addr);
  assign hit_cmp = (a32 >= CMP_BASE) && (a32 < CMP_BASE + CMP_BYTES);
  assign cmp_idx = IDX_W'(a32 - CMP_BASE);

  // register writes; unassigned and read-only addresses fall through
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      ovm_q  <= '0;
      ovd_q  <= '0;
      disc_q <= '0;
      for (int i = 0; i < CMP_BYTES; i++) cmp_mem[i] <= '0;
    end else if (wr) begin
      // lane j at CTL_BASE+j carries the upper channels first
      for (int j = 0; j < CTL_BYTES; j++) begin
        if (a32 == CTL_BASE + j)
          ctl_q[(CTL_BYTES-1-j)*DATA_W +: DATA_W] <= wdata;
      end
      if (a32 == OVM_ADDR)  ovm_q  <= wdata[NCH-1:0];
      if (a32 == OVD_ADDR)  ovd_q  <= wdata[NCH-1:0];
      if (a32 == DISC_ADDR) disc_q <= wdata[NCH-1:0];
      if (hit_cmp)          cmp_mem[cmp_idx] <= wdata;
    end
  end

  // read multiplexer; anything not decoded returns zero
  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < BPC; b++) begin
      if (a32 == CNT_BASE + b)
        rd_mux = DATA_W'(cnt >> (DATA_W*(BPC-1-b)));
    end
    for (int j = 0; j < CTL_BYTES; j++) begin
      if (a32 == CTL_BASE + j)
        rd_mux = DATA_W'(ctl_q >> (DATA_W*(CTL_BYTES-1-j)));
    end
    if (a32 == OVM_ADDR)  rd_mux = DATA_W'(ovm_q);
    if (a32 == OVD_ADDR)  rd_mux = DATA_W'(ovd_q);
    if (a32 == DISC_ADDR) rd_mux = DATA_W'(disc_q);
    if (hit_cmp)          rd_mux = cmp_mem[cmp_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd ? rd_mux : '0;
  end

  // compare bytes are stored high byte first per channel
  for (genvar c = 0; c < NCH; c++) begin : g_cmp
    for (genvar b = 0; b < BPC; b++) begin : g_byte
      assign cmp_flat[c*CNT_W + (BPC-1-b)*DATA_W +: DATA_W] = cmp_mem[c*BPC + b];
    end
  end

  assign ctl_vec   = ctl_q;
  assign ov_mask   = ovm_q;
  assign ov_data   = ovd_q;
  assign disc_mask = disc_q;

endmodule

// File: rtl/cmp_chan_slice.sv
module cmp_chan_slice
  import cmp_out_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [1:0]       code,
  input  logic             disc,
  input  logic             ovr_en,
  input  logic             ovr_val,
  input  logic             ovr_hit,
  output logic             match_o,
  output logic             pin_o,
  output logic             oe_o
);

  act_e act;
  logic owned;
  logic match_q, pin_q, oe_q;

  assign act   = act_e'(code);
  assign owned = !disc && (ovr_en || (act != ACT_NONE));

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= 1'b0;
      pin_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      match_q <= (cnt == cmp_val);
      oe_q    <= owned;
      if (!disc) begin
        if (ovr_en) begin
          if (ovr_hit) pin_q <= ovr_val;
        end else if (match_q) begin
          case (act)
            ACT_TOGGLE: pin_q <= !pin_q;
            ACT_CLEAR:  pin_q <= 1'b0;
            ACT_SET:    pin_q <= 1'b1;
            default:    pin_q <= pin_q;
          endcase
        end
      end
    end
  end

  assign match_o = match_q;
  assign pin_o   = pin_q;
  assign oe_o    = oe_q;

endmodule

// File: rtl/cmp_out_unit.sv
module cmp_out_unit
  import cmp_out_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pin_o,
  output logic [NCH-1:0]    pin_oe_o
);

  logic [CNT_W-1:0]     cnt;
  logic [2*NCH-1:0]     ctl_vec;
  logic [NCH*CNT_W-1:0] cmp_flat;
  logic [NCH-1:0]       ov_mask, ov_data, disc_mask, match_vec;

  cmp_free_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .cnt_o (cnt)
  );

  cmp_reg_bank #(
    .NCH(NCH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr        (bus_wr),
    .rd        (bus_rd),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .cnt       (cnt),
    .rdata     (bus_rdata),
    .ctl_vec   (ctl_vec),
    .cmp_flat  (cmp_flat),
    .ov_mask   (ov_mask),
    .ov_data   (ov_data),
    .disc_mask (disc_mask)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    cmp_chan_slice #(.CNT_W(CNT_W)) u_slice (
      .clk     (clk),
      .rst     (rst),
      .cnt     (cnt),
      .cmp_val (cmp_flat[c*CNT_W +: CNT_W]),
      .code    (ctl_vec[2*c +: 2]),
      .disc    (disc_mask[c]),
      .ovr_en  (ov_mask[c]),
      .ovr_val (ov_data[c]),
      .ovr_hit (match_vec[NCH-1]),
      .match_o (match_vec[c]),
      .pin_o   (pin_o[c]),
      .oe_o    (pin_oe_o[c])
    );
  end

endmodule

// File: rtl/cmp_out_unit_chk.sv
module cmp_out_unit_chk
  import cmp_out_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int CNT_W = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NCH-1:0]       pin_o,
  input logic [NCH-1:0]       pin_oe_o,
  input logic [NCH-1:0]       match_vec,
  input logic [CNT_W-1:0]     cnt,
  input logic [NCH*CNT_W-1:0] cmp_flat,
  input logic [2*NCH-1:0]     ctl_vec,
  input logic [NCH-1:0]       disc,
  input logic [NCH-1:0]       ov_mask
);

  // R1
  reset_outputs_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_o == '0 && pin_oe_o == '0));

  // R11
  counter_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cnt == CNT_W'($past(cnt) + 1'b1)));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic [1:0] code_c;
    assign code_c = ctl_vec[2*c +: 2];

    // R10
    match_single_chk: assert property (@(posedge clk) disable iff (rst)
      (match_vec[c] && $stable(cmp_flat[c*CNT_W +: CNT_W])) |=> !match_vec[c]);

    // R3
    toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
      (code_c == ACT_TOGGLE && !disc[c] && !ov_mask[c] && match_vec[c])
        |=> (pin_o[c] != $past(pin_o[c])));

    // R5
    idle_code_chk: assert property (@(posedge clk) disable iff (rst)
      (code_c == ACT_NONE && !ov_mask[c]) |=> (!pin_oe_o[c] && $stable(pin_o[c])));

    // R7
    disc_hold_chk: assert property (@(posedge clk) disable iff (rst)
      disc[c] |=> (!pin_oe_o[c] && $stable(pin_o[c])));

    // R8
    bcast_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (ov_mask[c] && !match_vec[NCH-1]) |=> $stable(pin_o[c]));
  end

endmodule

bind cmp_out_unit cmp_out_unit_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pin_o     (pin_o),
  .pin_oe_o  (pin_oe_o),
  .match_vec (match_vec),
  .cnt       (cnt),
  .cmp_flat  (cmp_flat),
  .ctl_vec   (ctl_vec),
  .disc      (disc_mask),
  .ov_mask   (ov_mask)
);

// File: tb/cmp_out_unit_tb.sv
`timescale 1ns/1ps
module cmp_out_unit_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_o, pin_oe_o;

  int total = 0;
  int bad   = 0;
  logic [15:0] tb_cnt;

  always #4 clk = ~clk;

  cmp_out_unit u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o)
  );

  // model of R11: zero after reset, +1 per clock
  always_ff @(posedge clk) begin
    if (rst) tb_cnt <= '0;
    else     tb_cnt <= tb_cnt + 1'b1;
  end

  // vector: {channel[2:0], code[1:0], expected pin, expected enable}
  localparam logic [6:0] VEC [8] = '{
    {3'd2, 2'b11, 1'b1, 1'b1},
    {3'd2, 2'b01, 1'b0, 1'b1},
    {3'd2, 2'b01, 1'b1, 1'b1},
    {3'd2, 2'b10, 1'b0, 1'b1},
    {3'd2, 2'b00, 1'b0, 1'b0},
    {3'd5, 2'b01, 1'b1, 1'b1},
    {3'd5, 2'b11, 1'b1, 1'b1},
    {3'd5, 2'b10, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  // schedule a match about 24 clocks ahead; low byte first
  task automatic fire(input int ch);
    logic [15:0] tgt;
    tgt = tb_cnt + 16'd24;
    wr(5'(16 + 2*ch + 1), tgt[7:0]);
    wr(5'(16 + 2*ch), tgt[15:8]);
    repeat (40) @(negedge clk);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] exp_lo;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 pins", {8'h0, pin_o}, 16'h0);
    check("R1 enables", {8'h0, pin_oe_o}, 16'h0);
    rd(5'h08, d); check("R1 ctl hi", {8'h0, d}, 16'h0);
    rd(5'h09, d); check("R1 ctl lo", {8'h0, d}, 16'h0);
    rd(5'h02, d); check("R1 bcast mask", {8'h0, d}, 16'h0);
    rd(5'h0A, d); check("R1 disc mask", {8'h0, d}, 16'h0);
    rd(5'h1F, d); check("R1 cmp7 lo", {8'h0, d}, 16'h0);

    // R11 counter read: value at the capturing edge
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 5'h01; exp_lo = tb_cnt[7:0];
    @(negedge clk);
    check("R11 counter low byte", {8'h0, bus_rdata}, {8'h0, exp_lo});
    bus_rd = 1'b0;

    // R2 and R6: layout and enables; ch7=11 ch6=00 ch5=01 ch4=10
    wr(5'h08, 8'hC6);
    rd(5'h08, d); check("R2 readback hi", {8'h0, d}, 16'h00C6);
    settle(); check("R6 enables hi byte", {8'h0, pin_oe_o}, 16'h00B0);
    // ch3=01 ch0=11
    wr(5'h09, 8'h43);
    rd(5'h09, d); check("R2 readback lo", {8'h0, d}, 16'h0043);
    settle(); check("R6 enables both", {8'h0, pin_oe_o}, 16'h00B9);
    wr(5'h08, 8'h00); wr(5'h09, 8'h00);
    settle(); check("R5 enables cleared", {8'h0, pin_oe_o}, 16'h0);

    // table: R3 toggle, R4 set/clear, R5 none, R10 single action per pass
    for (int k = 0; k < 8; k++) begin
      logic [2:0] chn;
      logic [1:0] code;
      chn  = VEC[k][6:4];
      code = VEC[k][3:2];
      wr(chn >= 3'd4 ? 5'h08 : 5'h09, 8'(code) << (2 * (chn % 4)));
      fire(int'(chn));
      check($sformatf("R3/R4/R5/R10 vec%0d pin", k), {15'h0, pin_o[chn]}, {15'h0, VEC[k][1]});
      check($sformatf("R6 vec%0d enable", k), {15'h0, pin_oe_o[chn]}, {15'h0, VEC[k][0]});
    end
    wr(5'h08, 8'h00);

    // R7 disconnect on channel 1 (code 01 at 0x09 bits [3:2])
    wr(5'h09, 8'h04);
    fire(1);
    check("R7 pre toggle", {15'h0, pin_o[1]}, 16'h1);
    wr(5'h0A, 8'h02);
    settle();
    check("R7 enable dropped", {15'h0, pin_oe_o[1]}, 16'h0);
    fire(1);
    check("R7 pin held", {15'h0, pin_o[1]}, 16'h1);
    wr(5'h0A, 8'h00);
    settle();
    check("R7 enable back", {15'h0, pin_oe_o[1]}, 16'h1);
    fire(1);
    check("R7 toggle resumes", {15'h0, pin_o[1]}, 16'h0);
    wr(5'h09, 8'h00);

    // R8 broadcast on channel 3 (own code 11 at 0x09 bits [7:6])
    wr(5'h09, 8'hC0);
    wr(5'h03, 8'h08);
    wr(5'h02, 8'h08);
    fire(3);
    check("R8 own match ignored", {15'h0, pin_o[3]}, 16'h0);
    fire(7);
    check("R8 preset one", {15'h0, pin_o[3]}, 16'h1);
    check("R8 enable", {15'h0, pin_oe_o[3]}, 16'h1);
    check("R8 ch7 pin idle", {14'h0, pin_oe_o[7], pin_o[7]}, 16'h0);
    wr(5'h03, 8'h00);
    fire(7);
    check("R8 preset zero", {15'h0, pin_o[3]}, 16'h0);
    wr(5'h02, 8'h00);
    fire(3);
    check("R8 own action back", {15'h0, pin_o[3]}, 16'h1);
    wr(5'h09, 8'h00);

    // R9 unassigned addresses
    wr(5'h05, 8'hFF);
    rd(5'h05, d); check("R9 hole 0x05", {8'h0, d}, 16'h0);
    wr(5'h0C, 8'hFF);
    rd(5'h0C, d); check("R9 hole 0x0C", {8'h0, d}, 16'h0);
    rd(5'h0A, d); check("R9 disc untouched", {8'h0, d}, 16'h0);
    rd(5'h03, d); check("R9 preset untouched", {8'h0, d}, 16'h0);
    wr(5'h01, 8'h00);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 5'h01; exp_lo = tb_cnt[7:0];
    @(negedge clk);
    check("R9 counter not writable", {8'h0, bus_rdata}, {8'h0, exp_lo});
    bus_rd = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule